// File: doc/BRIEF.md
# Bus Quiesce Handshake Controller

This block lets software take one power domain's bus port out of service before that domain's power changes, and bring it back after. Software writes a control word in which the upper half holds one write-enable bit for each bit of the lower half. Only the enabled request bits change, so any request bit can be set or cleared without reading the register first. The request bits drive the idle-request lines towards the interconnect's port logic. The port logic answers on an acknowledge vector and an idle vector, and both go through synchronizer flops before the block uses them.

A parameter mask selects which request bits belong to the domain that is handshaked. When an accepted write touches any of those bits, the block runs two waits in a fixed order. First the masked acknowledge bits must reach the requested state. Then the masked idle bits must reach it. Each wait has its own cycle budget. The block reports `done_o` when both waits succeed, or `timeout_o` together with the phase that failed. While a handshake is running, `busy_o` is high and every write is dropped. A write that touches no masked bit, including every write when the mask is zero, completes in the next cycle without a handshake.

Top module: `bus_quiesce_ctrl`

## Requirements
- R1: A write changes request bit i only when bit LANES+i of `wr_data` is 1, and then copies bit i of `wr_data` into it. The control readback (`rd_sel`=0) returns the request bits in [LANES-1:0] and zeros above.
- R2: `idle_req_o` always equals the request bits. Writing a request bit with its enable set to 1 asserts that line. Writing the enable alone clears it.
- R3: An accepted write whose enables select none of the `REQ_MASK` bits raises `done_o` in the cycle after the write and never raises `busy_o`.
- R4: The target is "enter idle" when any masked request bit is 1 after the write, and "leave" otherwise. The acknowledge wait ends when every masked acknowledge bit is 1 (enter) or 0 (leave).
- R5: The idle wait starts only after the acknowledge wait has ended. It ends when "all masked idle bits are 1" equals the target. Idle alone never completes a handshake.
- R6: Each wait gives up after CYC_PER_US*TIMEOUT_US cycles without a match. A stall in the acknowledge wait raises `timeout_o` exactly that many cycles after the write edge, with `err_phase_o`=0. A stall in the idle wait reports `err_phase_o`=1.
- R7: Any write presented while `busy_o` is 1 is dropped, including a write in the cycle in which the handshake ends. The first write after that is accepted.
- R8: The status readback (`rd_sel`=1) returns the acknowledge vector in [LANES-1:0] and the idle vector above it, through SYNC_STAGES synchronizer flops plus the read register. With SYNC_STAGES=2 that is 3 cycles after the input changes.
- R9: After reset, the request bits, readback, `busy_o`, `done_o`, `timeout_o` and `err_phase_o` are all 0.
- R10: `done_o` and `timeout_o` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 2*LANES | Upper half: per-bit enables. Lower half: request values |
| rd_sel | input | 1 | Readback select: 0 control, 1 status |
| rd_data | output | 2*LANES | Registered readback word |
| idle_req_o | output | LANES | Idle request lines to the port logic |
| ack_i | input | LANES | Acknowledge from the port logic (asynchronous) |
| idle_i | input | LANES | Idle status from the port logic (asynchronous) |
| busy_o | output | 1 | Handshake in progress, writes dropped |
| done_o | output | 1 | One-cycle pulse: handshake or immediate write finished |
| timeout_o | output | 1 | One-cycle pulse: a wait ran out of cycles |
| err_phase_o | output | 1 | Phase of the last timeout: 0 acknowledge, 1 idle |

## Verification
The end of a handshake and a new software write can land on the same clock edge. The bench provokes this by holding the acknowledge line wrong, so that the wait stalls. It then presents a write exactly in the cycle whose edge raises `timeout_o`. The check is that this write leaves `idle_req_o` unchanged, and that a write one cycle later is accepted and answered by `done_o`. A sweep over every enable/value combination on the low request bits also exercises the two immediate and handshaked paths against a responding port stub.

// File: rtl/bqc_pkg.sv
package bqc_pkg;
  typedef enum logic [1:0] {
    HS_REST  = 2'd0,
    HS_ACK   = 2'd1,
    HS_QUIET = 2'd2
  } hs_state_t;
endpackage

// File: rtl/bqc_sync.sv
module bqc_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bqc_req_reg.sv
module bqc_req_reg #(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [LANES-1:0] en_bits,
  input  logic [LANES-1:0] val_bits,
  output logic [LANES-1:0] q,
  output logic [LANES-1:0] nxt
);
  assign nxt = (q & ~en_bits) | (val_bits & en_bits);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (accept) q <= nxt;
  end
endmodule

// File: rtl/bqc_handshake.sv
module bqc_handshake
  import bqc_pkg::*;
#(
  parameter int               LANES    = 16,
  parameter logic [LANES-1:0] REQ_MASK = 16'h0001,
  parameter int               LIMIT    = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_hs,
  input  logic             go_now,
  input  logic             go_target,
  input  logic [LANES-1:0] ack_s,
  input  logic [LANES-1:0] idle_s,
  output logic             busy,
  output logic             done,
  output logic             tmo,
  output logic             phase
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  hs_state_t      state;
  logic [CW-1:0]  cnt;
  logic           tgt;
  logic           ack_ok;
  logic           idle_ok;

  assign ack_ok  = (ack_s & REQ_MASK) == (tgt ? REQ_MASK : '0);
  assign idle_ok = (((idle_s & REQ_MASK) == REQ_MASK) == tgt);
  assign busy    = (state != HS_REST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HS_REST;
      cnt   <= '0;
      tgt   <= 1'b0;
      done  <= 1'b0;
      tmo   <= 1'b0;
      phase <= 1'b0;
    end else begin
      done <= 1'b0;
      tmo  <= 1'b0;
      case (state)
        HS_REST: begin
          if (go_hs) begin
            state <= HS_ACK;
            cnt   <= '0;
            tgt   <= go_target;
          end else if (go_now) begin
            done <= 1'b1;
          end
        end
        HS_ACK: begin
          if (ack_ok) begin
            state <= HS_QUIET;
            cnt   <= '0;
          end else if (cnt == LAST) begin
            state <= HS_REST;
            tmo   <= 1'b1;
            phase <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        HS_QUIET: begin
          if (idle_ok) begin
            state <= HS_REST;
            done  <= 1'b1;
          end else if (cnt == LAST) begin
            state <= HS_REST;
            tmo   <= 1'b1;
            phase <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= HS_REST;
      endcase
    end
  end
endmodule

// File: rtl/bus_quiesce_ctrl.sv
module bus_quiesce_ctrl #(
  parameter int               LANES       = 16,
  parameter logic [LANES-1:0] REQ_MASK    = 16'h0001,
  parameter int               CYC_PER_US  = 100,
  parameter int               TIMEOUT_US  = 10000,
  parameter int               SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2*LANES-1:0] wr_data,
  input  logic               rd_sel,
  output logic [2*LANES-1:0] rd_data,
  output logic [LANES-1:0]   idle_req_o,
  input  logic [LANES-1:0]   ack_i,
  input  logic [LANES-1:0]   idle_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic               err_phase_o
);
  localparam int WORD  = 2 * LANES;
  localparam int LIMIT = CYC_PER_US * TIMEOUT_US;

  logic [LANES-1:0] en_bits, val_bits, req_q, req_nxt;
  logic [LANES-1:0] ack_s, idle_s;
  logic             accept, touch;

  assign en_bits  = wr_data[WORD-1:LANES];
  assign val_bits = wr_data[LANES-1:0];
  assign accept   = wr_en & ~busy_o;
  assign touch    = |(en_bits & REQ_MASK);

  bqc_req_reg #(.LANES(LANES)) u_req (
    .clk(clk), .rst(rst), .accept(accept),
    .en_bits(en_bits), .val_bits(val_bits),
    .q(req_q), .nxt(req_nxt)
  );

  bqc_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sync_ack (
    .clk(clk), .rst(rst), .d(ack_i), .q(ack_s)
  );

  bqc_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sync_idle (
    .clk(clk), .rst(rst), .d(idle_i), .q(idle_s)
  );

  bqc_handshake #(.LANES(LANES), .REQ_MASK(REQ_MASK), .LIMIT(LIMIT)) u_hs (
    .clk(clk), .rst(rst),
    .go_hs(accept & touch),
    .go_now(accept & ~touch),
    .go_target(|(req_nxt & REQ_MASK)),
    .ack_s(ack_s), .idle_s(idle_s),
    .busy(busy_o), .done(done_o), .tmo(timeout_o), .phase(err_phase_o)
  );

  assign idle_req_o = req_q;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_sel) rd_data <= {idle_s, ack_s};
    else rd_data <= {{LANES{1'b0}}, req_q};
  end
endmodule

// File: rtl/bus_quiesce_chk.sv
module bus_quiesce_chk #(
  parameter int               LANES    = 16,
  parameter logic [LANES-1:0] REQ_MASK = 16'h0001
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [2*LANES-1:0] wr_data,
  input logic [LANES-1:0]   idle_req_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               timeout_o
);
  assert_masked_write_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_o) |=>
      (((idle_req_o ^ $past(idle_req_o)) & ~$past(wr_data[2*LANES-1:LANES])) == '0));

  assert_refuse_busy_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !busy_o) |=> $stable(idle_req_o));

  assert_immediate_done_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_o && ((wr_data[2*LANES-1:LANES] & REQ_MASK) == '0)) |=>
      (done_o && !busy_o));

  assert_timeout_from_wait_R6: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> ($past(busy_o) && !busy_o));

  assert_exclusive_pulses_R10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (done_o || timeout_o) |=> !timeout_o);
endmodule

bind bus_quiesce_ctrl bus_quiesce_chk #(.LANES(LANES), .REQ_MASK(REQ_MASK)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .idle_req_o(idle_req_o), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/test_bus_quiesce_ctrl.sv
module test_bus_quiesce_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam logic [15:0] MASK = 16'h0005;
  localparam int CPU = 4;
  localparam int TUS = 3;
  localparam int LIMIT = CPU * TUS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [15:0] idle_req_o, ack_i, idle_i;
  logic        busy_o, done_o, timeout_o, err_phase_o;

  logic        stub_on = 1'b0;
  logic [15:0] man_ack = '0, man_idle = '0;
  logic        s_d1 = 1'b0, s_d2 = 1'b0;
  logic [15:0] stub_ack = '0, stub_idle = '0;
  int          nchk = 0, nfail = 0, both_cnt = 0;

  assign ack_i  = stub_on ? stub_ack  : man_ack;
  assign idle_i = stub_on ? stub_idle : man_idle;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_quiesce_ctrl #(.LANES(LANES), .REQ_MASK(MASK), .CYC_PER_US(CPU),
                     .TIMEOUT_US(TUS), .SYNC_STAGES(2)) i_bus_quiesce_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .idle_req_o(idle_req_o), .ack_i(ack_i), .idle_i(idle_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .err_phase_o(err_phase_o)
  );

  // port-logic stub: acknowledge follows the masked request, idle follows acknowledge
  always @(negedge clk) begin
    s_d1      <= |(idle_req_o & MASK);
    s_d2      <= s_d1;
    stub_ack  <= s_d2 ? MASK : 16'h0;
    stub_idle <= (stub_ack == MASK) ? MASK : 16'h0;
    if (done_o && timeout_o) both_cnt <= both_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_end(output int k, output logic to);
    k = 0;
    while (!(done_o || timeout_o) && k < 200) begin
      @(negedge clk); k++;
    end
    to = timeout_o;
  endtask

  task automatic read_word(input logic sel, output logic [31:0] v);
    @(negedge clk); rd_sel = sel;
    @(negedge clk); v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] model;
    logic [31:0] v;
    int          k;
    logic        to;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(idle_req_o == 0 && !busy_o && !done_o && !timeout_o && !err_phase_o,
        "R9 reset outputs", {12'h0, busy_o, done_o, timeout_o, err_phase_o, idle_req_o}, 32'h0);
    read_word(1'b0, v);
    chk(v == 32'h0, "R9 reset readback", v, 32'h0);

    // sweep of enables x values on the low four request bits against the stub
    stub_on = 1'b1;
    model = '0;
    for (int we = 0; we < 16; we++) begin
      for (int d = 0; d < 16; d++) begin
        logic touch;
        touch = |(we[3:0] & MASK[3:0]);
        model = (model & ~{12'h0, we[3:0]}) | ({12'h0, d[3:0]} & {12'h0, we[3:0]});
        do_write({12'h0, we[3:0], 12'h0, d[3:0]});
        wait_end(k, to);
        chk(!to, "R4 handshake completes with responding stub", {31'h0, to}, 32'h0);
        if (!touch) chk(k == 0, "R3 immediate completion", k, 0);
        else chk(k >= 2, "R5 acknowledge then idle takes two waits", k, 2);
        chk(idle_req_o == model, "R2 request lines mirror register", idle_req_o, model);
        @(negedge clk);
        chk(!done_o && !timeout_o, "R10 done is one cycle", {done_o, timeout_o}, 0);
        read_word(1'b0, v);
        chk(v == {16'h0, model}, "R1 masked write readback", v, {16'h0, model});
      end
    end

    // clear all request bits with the stub
    do_write(32'hFFFF_0000);
    wait_end(k, to);
    chk(!to && idle_req_o == 0, "R2 enable alone clears", idle_req_o, 0);
    stub_on = 1'b0;
    man_ack = '0; man_idle = '0;
    repeat (4) @(negedge clk);

    // R8 synchronizer latency on the status readback
    rd_sel = 1'b1;
    man_ack = 16'h00A5; man_idle = 16'h3C00;
    @(negedge clk);
    @(negedge clk);
    chk(rd_data == 32'h0, "R8 not visible after two edges", rd_data, 32'h0);
    @(negedge clk);
    chk(rd_data == 32'h3C00_00A5, "R8 visible after three edges", rd_data, 32'h3C00_00A5);
    rd_sel = 1'b0;

    // R6/R5: idle present but no acknowledge -> acknowledge-phase timeout
    man_ack = '0; man_idle = MASK;
    repeat (4) @(negedge clk);
    do_write(32'h0005_0005);
    chk(busy_o, "R7 busy during handshake", {31'h0, busy_o}, 1);
    wait_end(k, to);
    chk(to && k == LIMIT, "R6 ack timeout cycle count", k, LIMIT);
    chk(!err_phase_o, "R5 idle alone does not complete, phase ack", {31'h0, err_phase_o}, 0);

    // R6: acknowledge given, idle never -> idle-phase timeout one cycle later
    man_ack = MASK; man_idle = '0;
    repeat (4) @(negedge clk);
    do_write(32'h0005_0005);
    wait_end(k, to);
    chk(to && k == LIMIT + 1, "R6 idle timeout cycle count", k, LIMIT + 1);
    chk(err_phase_o, "R6 idle phase reported", {31'h0, err_phase_o}, 1);

    // R7: leave stalls on a held acknowledge; writes mid-wait and at the timeout edge dropped
    man_ack = MASK; man_idle = '0;
    repeat (4) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h0005_0000;
    @(negedge clk); wr_en = 1'b0;
    chk(idle_req_o == 0, "R2 leave write clears", idle_req_o, 0);
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0002_0002;
    @(negedge clk); wr_en = 1'b0;
    chk(idle_req_o == 0, "R7 write during wait dropped", idle_req_o, 0);
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0005_0005;
    @(negedge clk);
    chk(timeout_o, "R6 leave timeout at limit", {31'h0, timeout_o}, 1);
    chk(idle_req_o == 0, "R7 write on ending edge dropped", idle_req_o, 0);
    wr_data = 32'h0002_0002;
    @(negedge clk); wr_en = 1'b0;
    chk(done_o && idle_req_o == 16'h0002, "R7 next write accepted", idle_req_o, 16'h0002);
    chk(!busy_o, "R3 no busy on immediate write", {31'h0, busy_o}, 0);

    chk(both_cnt == 0, "R10 done and timeout never together", both_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule